// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block sits on the receive byte stream of an Ethernet MAC and decides, from the first six bytes of each frame, whether the frame is for this station. The six bytes form the destination address. The block checks that address against four rules. Promiscuous mode accepts every frame. A broadcast address is accepted unless broadcast rejection is enabled. A group (multicast) address is accepted when its bit is set in a 64-entry hash table. Any other address is accepted only when it equals the programmed station address.

The hash slot comes from a CRC-32 computed over the address as the bytes arrive. Bit 0 of the final CRC chooses one of two 32-bit table halves. The next five CRC bits, taken in reverse order, give the bit position inside that half. Software programs the station address, both table halves and the control bits through a simple write port. Each frame uses the settings that were in force when its first byte arrived.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, `verdict_vld` and `verdict_accept` are 0, and every configuration register reads as zero for the purposes of filtering.
- R2: `verdict_vld` is high for exactly one cycle, in the cycle after the sixth address byte is taken. A byte counts only when `byte_vld` is high. The first byte is the one carrying `sof`. Bytes after the sixth, and bytes that arrive with no preceding `sof`, produce no verdict.
- R3: A byte taken with `sof` clears `verdict_accept` from the next cycle on. Apart from that, `verdict_accept` holds its value from one verdict until the next `sof`.
- R4: An address whose first byte has bit 0 clear is accepted only when all 48 bits equal the station address. The station address is built from two registers. The upper register holds byte 0 in [31:24], byte 1 in [23:16], byte 2 in [15:8] and byte 3 in [7:0]. The lower register holds byte 4 in [31:24] and byte 5 in [23:16].
- R5: The hash CRC starts at 0xFFFFFFFF. The address bytes are fed in arrival order, each byte least-significant bit first. For each bit the register shifts left by one, and 0x04C11DB7 is XORed in when the old bit 31 differs from the incoming bit.
- R6: For a group address that is not broadcast, CRC bit 0 selects the table half: 1 selects the high half and 0 the low half. The bit index within that half is {crc[1],crc[2],crc[3],crc[4],crc[5]}, with crc[1] as the index MSB. The frame is accepted exactly when that bit is 1.
- R7: An all-ones destination is accepted when control bit 1 (broadcast reject) is 0, and rejected when it is 1.
- R8: When control bit 0 (promiscuous) is 1, every frame is accepted, whatever its address and the other settings.
- R9: A configuration write made in the `sof` cycle of a frame or later does not affect that frame's verdict. It applies from the next frame.
- R10: Write-port offsets are as follows. 0 is the upper station word, 1 the lower station word, 2 the high hash half, 3 the low hash half and 4 the control word. Writes to other offsets have no effect.
- R11: Idle cycles (`byte_vld` low) between address bytes do not change the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_vld | input | 1 | Receive byte valid |
| sof | input | 1 | First byte of a frame; sampled only with byte_vld |
| byte_data | input | 8 | Receive byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| verdict_vld | output | 1 | One-cycle pulse: verdict available |
| verdict_accept | output | 1 | 1 = accept frame; held until next sof |

## Verification
The bench aims at the hash path. It computes the table slot of a chosen group address with its own CRC loop and then sets only that bit, or only the same bit in the other half. A design with the index bits reversed the wrong way, or with the halves swapped, would reject the first case or accept the second. A unicast address that differs only in its last byte catches a comparison that ignores the lower station word. Broadcast is checked with rejection both on and off, and again under promiscuous mode, which must win. A station write made in the middle of a frame must leave that frame's verdict alone and take effect on the next one. Trailing bytes, stray bytes before any `sof`, and gaps between bytes must neither add verdicts nor change them.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam logic [31:0] RXF_POLY = 32'h04C11DB7;

  localparam int unsigned REG_STA_HI  = 0;
  localparam int unsigned REG_STA_LO  = 1;
  localparam int unsigned REG_HASH_HI = 2;
  localparam int unsigned REG_HASH_LO = 3;
  localparam int unsigned REG_CTRL    = 4;

  localparam int unsigned CTRL_PROMISC = 0;
  localparam int unsigned CTRL_BC_REJ  = 1;

  // advance the CRC by one byte, least-significant bit first
  function automatic logic [31:0] crc_step_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int k = 0; k < 8; k++) begin
      if (r[31] ^ b[k]) r = (r << 1) ^ RXF_POLY;
      else              r = r << 1;
    end
    return r;
  endfunction

  // {half_select, index[4:0]} with index = reversed crc[5:1]
  function automatic logic [5:0] hash_slot(input logic [31:0] c);
    logic [4:0] idx;
    for (int k = 0; k < 5; k++) idx[4-k] = c[k+1];
    return {c[0], idx};
  endfunction
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs #(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          frame_start,
  output logic [DW-1:0] sta_hi,
  output logic [DW-1:0] sta_lo,
  output logic [DW-1:0] hash_hi,
  output logic [DW-1:0] hash_lo,
  output logic          promisc,
  output logic          bc_rej
);
  import rxf_pkg::*;
  localparam int unsigned NREG = 5;

  logic [DW-1:0] live_q [NREG];
  logic [DW-1:0] snap_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q[g] <= '0;
        snap_q[g] <= '0;
      end else begin
        if (we && (addr == AW'(g))) live_q[g] <= wdata;
        if (frame_start)           snap_q[g] <= live_q[g];
      end
    end
  end

  assign sta_hi  = snap_q[REG_STA_HI];
  assign sta_lo  = snap_q[REG_STA_LO];
  assign hash_hi = snap_q[REG_HASH_HI];
  assign hash_lo = snap_q[REG_HASH_LO];
  assign promisc = snap_q[REG_CTRL][CTRL_PROMISC];
  assign bc_rej  = snap_q[REG_CTRL][CTRL_BC_REJ];
endmodule

// File: rtl/rxf_hdr_track.sv
module rxf_hdr_track #(
  parameter int unsigned DA_BYTES = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  byte_vld,
  input  logic                  sof,
  input  logic [7:0]            byte_data,
  output logic                  frame_start,
  output logic                  last_byte,
  output logic [DA_BYTES*8-1:0] da_fin,
  output logic [31:0]           crc_fin
);
  import rxf_pkg::*;
  localparam int unsigned DAW = DA_BYTES * 8;
  localparam int unsigned CW  = $clog2(DA_BYTES + 1);

  logic [CW-1:0]  cnt_q;
  logic           in_q;
  logic [DAW-1:0] da_q;
  logic [31:0]    crc_q;
  logic           take_more;
  logic           take_any;

  assign frame_start = byte_vld & sof;
  assign take_more   = byte_vld & ~sof & in_q & (cnt_q < CW'(DA_BYTES));
  assign take_any    = frame_start | take_more;
  assign last_byte   = take_more & (cnt_q == CW'(DA_BYTES - 1));

  assign crc_fin = crc_step_byte(frame_start ? 32'hFFFF_FFFF : crc_q, byte_data);
  assign da_fin  = frame_start ? {{(DAW-8){1'b0}}, byte_data} : {da_q[DAW-9:0], byte_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      in_q  <= 1'b0;
      da_q  <= '0;
      crc_q <= '0;
    end else if (take_any) begin
      cnt_q <= frame_start ? CW'(1) : cnt_q + CW'(1);
      in_q  <= 1'b1;
      da_q  <= da_fin;
      crc_q <= crc_fin;
    end
  end
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide #(
  parameter int unsigned DA_BYTES = 6,
  parameter int unsigned DW = 32
) (
  input  logic [DA_BYTES*8-1:0] da,
  input  logic [31:0]           crc,
  input  logic [DW-1:0]         sta_hi,
  input  logic [DW-1:0]         sta_lo,
  input  logic [DW-1:0]         hash_hi,
  input  logic [DW-1:0]         hash_lo,
  input  logic                  promisc,
  input  logic                  bc_rej,
  output logic                  is_bcast,
  output logic                  is_group,
  output logic                  accept
);
  import rxf_pkg::*;
  localparam int unsigned DAW = DA_BYTES * 8;

  logic [DAW-1:0] station;
  logic [5:0]     slot;
  logic [DW-1:0]  half;
  logic           hash_hit;

  assign station  = {sta_hi, sta_lo[DW-1 -: DAW-DW]};
  assign slot     = hash_slot(crc);
  assign half     = slot[5] ? hash_hi : hash_lo;
  assign hash_hit = half[slot[4:0]];
  assign is_bcast = &da;
  assign is_group = da[DAW-8] & ~is_bcast;

  always_comb begin
    if (promisc)       accept = 1'b1;
    else if (is_bcast) accept = ~bc_rej;
    else if (is_group) accept = hash_hit;
    else               accept = (da == station);
  end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter #(
  parameter int unsigned DA_BYTES = 6,
  parameter int unsigned CFG_AW   = 3,
  parameter int unsigned CFG_DW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic              sof,
  input  logic [7:0]        byte_data,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic              verdict_vld,
  output logic              verdict_accept
);
  localparam int unsigned DAW = DA_BYTES * 8;

  logic              frame_start_w;
  logic              last_byte_w;
  logic [DAW-1:0]    da_w;
  logic [31:0]       crc_w;
  logic [CFG_DW-1:0] sta_hi_w, sta_lo_w, hash_hi_w, hash_lo_w;
  logic              promisc_w, bc_rej_w;
  logic              is_bcast_w, is_group_w, accept_w;

  rxf_cfg_regs #(.AW(CFG_AW), .DW(CFG_DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .frame_start(frame_start_w),
    .sta_hi(sta_hi_w), .sta_lo(sta_lo_w), .hash_hi(hash_hi_w), .hash_lo(hash_lo_w),
    .promisc(promisc_w), .bc_rej(bc_rej_w)
  );

  rxf_hdr_track #(.DA_BYTES(DA_BYTES)) u_trk (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .sof(sof), .byte_data(byte_data),
    .frame_start(frame_start_w), .last_byte(last_byte_w), .da_fin(da_w), .crc_fin(crc_w)
  );

  rxf_decide #(.DA_BYTES(DA_BYTES), .DW(CFG_DW)) u_dec (
    .da(da_w), .crc(crc_w),
    .sta_hi(sta_hi_w), .sta_lo(sta_lo_w), .hash_hi(hash_hi_w), .hash_lo(hash_lo_w),
    .promisc(promisc_w), .bc_rej(bc_rej_w),
    .is_bcast(is_bcast_w), .is_group(is_group_w), .accept(accept_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verdict_vld    <= 1'b0;
      verdict_accept <= 1'b0;
    end else if (frame_start_w) begin
      verdict_vld    <= 1'b0;
      verdict_accept <= 1'b0;
    end else if (last_byte_w) begin
      verdict_vld    <= 1'b1;
      verdict_accept <= accept_w;
    end else begin
      verdict_vld    <= 1'b0;
    end
  end
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
  input logic clk,
  input logic rst_n,
  input logic frame_start,
  input logic last_byte,
  input logic verdict_vld,
  input logic verdict_accept,
  input logic promisc,
  input logic bc_rej,
  input logic is_bcast
);
  p_vld_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte |=> verdict_vld);
  p_vld_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld |=> !verdict_vld);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !last_byte) |=> $stable(verdict_accept));
  p_sof_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!verdict_vld && !verdict_accept));
  p_promisc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && promisc) |=> verdict_accept);
  p_bcast_rej_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && !promisc && bc_rej && is_bcast) |=> !verdict_accept);
endmodule

bind rx_dest_filter rxf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start_w), .last_byte(last_byte_w),
  .verdict_vld(verdict_vld), .verdict_accept(verdict_accept),
  .promisc(promisc_w), .bc_rej(bc_rej_w), .is_bcast(is_bcast_w)
);

// File: tb/rx_dest_filter_tb_top.sv
module rx_dest_filter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_vld = 1'b0, sof = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        verdict_vld, verdict_accept;

  int checks = 0, fails = 0, verdicts = 0;
  bit exp_q[$];
  logic [31:0] m_reg [5];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_dest_filter dut_i (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .sof(sof), .byte_data(byte_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .verdict_vld(verdict_vld), .verdict_accept(verdict_accept)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench-side CRC over the flat 48-bit address, bit by bit
  function automatic logic [31:0] ref_crc(input logic [47:0] da);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int n = 0; n < 48; n++) begin
      logic inb;
      logic top;
      inb = da[47 - 8*(n/8) - 7 + (n%8)];
      top = c[31];
      c = {c[30:0], 1'b0};
      if (top != inb) c = c ^ 32'h04C11DB7;
    end
    return c;
  endfunction

  function automatic bit ref_accept(input logic [47:0] da);
    logic [31:0] c;
    logic [4:0]  ix;
    if (m_reg[4][0]) return 1;
    if (da == 48'hFFFF_FFFF_FFFF) return !m_reg[4][1];
    if (da[40]) begin
      c  = ref_crc(da);
      ix = {c[1], c[2], c[3], c[4], c[5]};
      return c[0] ? m_reg[2][ix] : m_reg[3][ix];
    end
    return da == {m_reg[0], m_reg[1][31:16]};
  endfunction

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a < 5) m_reg[a] = d;
  endtask

  // drives one frame; optional gaps, trailing bytes and a mid-frame write
  task automatic send_frame(input logic [47:0] da, input bit gaps, input int extra,
                            input bit midw, input logic [2:0] wa, input logic [31:0] wd);
    bit e;
    e = ref_accept(da);
    exp_q.push_back(e);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i == 1) check(verdict_accept == 0, "R3 sof clears accept", verdict_accept, 0);
      byte_vld = 1; sof = (i == 0); byte_data = da[47-8*i -: 8];
      cfg_we = (midw && i == 2); cfg_addr = wa; cfg_wdata = wd;
      if (gaps) begin
        @(negedge clk);
        byte_vld = 0; sof = 0; cfg_we = 0;
      end
    end
    for (int i = 0; i < extra; i++) begin
      @(negedge clk);
      byte_vld = 1; sof = 0; byte_data = 8'hFF; cfg_we = 0;
    end
    @(negedge clk);
    byte_vld = 0; sof = 0; cfg_we = 0;
    if (midw && wa < 5) m_reg[wa] = wd;
    repeat (3) @(negedge clk);
    check(verdict_accept == e, "R3 verdict held", verdict_accept, e);
  endtask

  // monitor: scoreboard pop and compare on each verdict pulse
  always @(negedge clk) begin
    if (rst_n && verdict_vld) begin
      verdicts++;
      if (exp_q.size() == 0) check(0, "R2 unexpected verdict", 1, 0);
      else begin
        bit e;
        e = exp_q.pop_front();
        check(verdict_accept == e, "R4-8 verdict", verdict_accept, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [47:0] sta, grp, grp2;
    logic [31:0] c;
    logic [4:0]  ix;
    int v0;
    for (int i = 0; i < 5; i++) m_reg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(verdict_vld == 0 && verdict_accept == 0, "R1 reset state", {verdict_vld, verdict_accept}, 0);

    // R2: stray bytes with no sof produce nothing
    v0 = verdicts;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); byte_vld = 1; sof = 0; byte_data = 8'h00;
    end
    @(negedge clk); byte_vld = 0;
    repeat (3) @(negedge clk);
    check(verdicts == v0, "R2 no sof no verdict", verdicts, v0);

    // R1: zero station at reset accepts all-zero unicast
    send_frame(48'h0, 0, 0, 0, 0, 0);

    // R10, R4 unicast
    sta = 48'h0211_2233_4455;
    cfg_write(3'd0, sta[47:16]);
    cfg_write(3'd1, {sta[15:0], 16'h0});
    cfg_write(3'd7, 32'hFFFF_FFFF);            // R10 unused offset ignored
    send_frame(sta, 0, 0, 0, 0, 0);           // R4 match
    send_frame(sta ^ 48'h1, 0, 0, 0, 0, 0);   // R4 last byte differs
    send_frame(sta ^ 48'h0000_0100_0000, 0, 0, 0, 0, 0);
    send_frame(sta, 1, 0, 0, 0, 0);           // R11 gaps
    v0 = verdicts;
    send_frame(sta, 0, 4, 0, 0, 0);           // R2 trailing bytes
    check(verdicts == v0 + 1, "R2 one verdict per frame", verdicts, v0 + 1);

    // R7 broadcast
    send_frame(48'hFFFF_FFFF_FFFF, 0, 0, 0, 0, 0);
    cfg_write(3'd4, 32'h2);
    send_frame(48'hFFFF_FFFF_FFFF, 0, 0, 0, 0, 0);
    // R8 promiscuous overrides
    cfg_write(3'd4, 32'h3);
    send_frame(48'hFFFF_FFFF_FFFF, 0, 0, 0, 0, 0);
    send_frame(48'h0A0B_0C0D_0E0F, 0, 0, 0, 0, 0);
    check(exp_q.size() == 0, "R8 all verdicts seen", exp_q.size(), 0);
    cfg_write(3'd4, 32'h0);

    // R5, R6 hash
    grp = 48'h0100_5E00_0001;
    c   = ref_crc(grp);
    ix  = {c[1], c[2], c[3], c[4], c[5]};
    cfg_write(c[0] ? 3'd2 : 3'd3, 32'h1 << ix);
    send_frame(grp, 0, 0, 0, 0, 0);           // R6 hit
    cfg_write(c[0] ? 3'd2 : 3'd3, 32'h0);
    cfg_write(c[0] ? 3'd3 : 3'd2, 32'h1 << ix);
    send_frame(grp, 0, 0, 0, 0, 0);           // R6 wrong half -> reject
    cfg_write(c[0] ? 3'd3 : 3'd2, ~(32'h1 << ix));
    cfg_write(c[0] ? 3'd2 : 3'd3, ~(32'h1 << ix));
    send_frame(grp, 0, 0, 0, 0, 0);           // R5 every bit but its own
    grp2 = 48'h3333_0000_00FB;
    send_frame(grp2, 1, 0, 0, 0, 0);
    cfg_write(3'd2, 32'hFFFF_FFFF);
    cfg_write(3'd3, 32'hFFFF_FFFF);
    send_frame(grp2, 0, 0, 0, 0, 0);

    // R9 mid-frame write
    send_frame(sta, 0, 0, 1, 3'd0, 32'h1122_3344);
    send_frame(sta, 0, 0, 0, 0, 0);
    send_frame({32'h1122_3344, sta[15:0]}, 0, 0, 0, 0, 0);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule